// File: doc/BRIEF.md
# Posted Write Buffer with Shared Data Pool

This block sits between a processor's write port and an external memory write port. Writes that may be posted are stored, and the processor moves on at once. The block then sends them to memory in the order they arrived. Each stored write takes one address entry. Its words come from a separate, shared pool of data slots. A run of writes to consecutive word addresses joins the most recent entry, so it costs one address entry plus one data slot per word.

Writes that may not be posted go straight to the memory port. Such a write is accepted only when the buffer holds nothing and memory takes the write in that same cycle. This covers writes to regions with neither the cache attribute nor the buffer attribute set, every write made while the enable input is low, and the write phase of a locked read-modify-write.

External aborts on posted writes are dropped. An abort on a direct write is returned to the processor.

Top module: `wbuf_top`

## Requirements
- R1: A synchronous active-low reset empties the buffer. After reset, `mem_valid` stays low until a write is presented.
- R2: Stored words are presented to memory in arrival order. The first word of an entry uses the entry's address, and each later word of that entry adds 4. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold their values.
- R3: The buffer holds at most 4 address entries and 8 data words. A posted write is refused (`cpu_wr_ready` low) in either of two cases: all 8 data slots are full, or all 4 entries are in use and the write cannot join the last one. Occupancy is measured at the start of the cycle.
- R4: A posted write joins the newest entry when its address equals that entry's address plus 4 times its word count. Joining takes one data slot and no address entry. There is one exception: if the newest entry is the only entry and its final word is accepted by memory in that same cycle, the write opens a new entry instead.
- R5: A write is posted only when `wb_enable` is high and at least one of `cpu_wr_cache` and `cpu_wr_buf` is high. Any other write is a direct write.
- R6: A direct write is driven onto the memory port in the same cycle it is presented. It is accepted only in a cycle where the buffer is empty and `mem_ready` is high.
- R7: A write with `cpu_wr_locked` high is always a direct write, whatever its attributes.
- R8: Lowering `wb_enable` does not discard stored writes. They drain normally, and new writes go direct.
- R9: `mem_abort` during a posted drain has no visible effect. During an accepted direct write, `mem_abort` is returned on `cpu_wr_abort` in that same cycle.
- R10: `mem_valid` is low whenever the buffer is empty and no direct write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_enable | input | 1 | Allows posting of writes |
| cpu_wr_valid | input | 1 | Processor presents a write |
| cpu_wr_ready | output | 1 | Write taken this cycle |
| cpu_wr_addr | input | AW | Byte address, word aligned |
| cpu_wr_data | input | DW | Write data |
| cpu_wr_cache | input | 1 | Region cache attribute |
| cpu_wr_buf | input | 1 | Region buffer attribute |
| cpu_wr_locked | input | 1 | Write phase of a locked read-modify-write |
| cpu_wr_abort | output | 1 | External abort on the accepted direct write |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_abort | input | 1 | Memory signals an error on the current write |

## Verification
The hardest case to reach is the boundary between joining and opening an entry. It happens when the newest entry is also the only one, and memory accepts its final word in the same cycle that a consecutive write arrives. The bench reaches this case by sending consecutive runs while `mem_ready` follows a pseudo-random pattern. A reference model built from queues predicts, every cycle, whether the run joins the entry or opens a new one. Pool exhaustion is reached separately. The bench holds `mem_ready` low so that nine consecutive words, or five scattered writes, meet a full buffer, then releases memory and checks that the stalled write goes through.

// File: rtl/wbuf_pkg.sv
// Shared constants and types for the posted write buffer.
// Assumes byte addressing with 4-byte words.
package wbuf_pkg;
    localparam int WB_WORD_SHIFT = 2;

    // Path a presented write takes through the block.
    typedef enum logic {
        ROUTE_DIRECT = 1'b0,
        ROUTE_POSTED = 1'b1
    } wb_route_e;
endpackage

// File: rtl/wbuf_addr_q.sv
// Address entry queue: each entry holds a base address and a word count.
// A new write either opens an entry or joins the newest one.
// The head entry also keeps an offset to the next word it will drain.
// Assumes ENTRIES is a power of two and a push and a merge never occur together.
module wbuf_addr_q
    import wbuf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              in_addr,
    input  logic                       push_new,
    input  logic                       push_merge,
    input  logic                       pop_word,
    output logic                       merge_hit,
    output logic                       full,
    output logic                       empty,
    output logic [AW-1:0]              head_addr,
    output logic [$clog2(ENTRIES):0]   used
);
    localparam int PW = $clog2(ENTRIES);
    localparam int CW = $clog2(WORDS) + 1;

    logic [AW-1:0] base_q [ENTRIES];
    logic [CW-1:0] cnt_q  [ENTRIES];
    logic [PW-1:0] hd_q, tl_q, last_idx;
    logic [PW:0]   used_q;
    logic [CW-1:0] off_q;
    logic          last_word, retire;
    logic [AW-1:0] tail_end;

    // Decode head and tail state for the merge and retire decisions.
    always_comb begin
        last_idx  = tl_q - 1'b1;
        empty     = (used_q == '0);
        full      = (used_q == (PW+1)'(ENTRIES));
        last_word = (off_q + 1'b1) == cnt_q[hd_q];
        retire    = pop_word && last_word;
        tail_end  = base_q[last_idx] + (AW'(cnt_q[last_idx]) << WB_WORD_SHIFT);
        merge_hit = !empty && (in_addr == tail_end)
                    && !((used_q == (PW+1)'(1)) && retire);
        head_addr = base_q[hd_q] + (AW'(off_q) << WB_WORD_SHIFT);
        used      = used_q;
    end

    // Pointer, occupancy and head word offset bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q   <= '0;
            tl_q   <= '0;
            used_q <= '0;
            off_q  <= '0;
        end else begin
            if (push_new) tl_q <= tl_q + 1'b1;
            if (retire) begin
                hd_q  <= hd_q + 1'b1;
                off_q <= '0;
            end else if (pop_word) begin
                off_q <= off_q + 1'b1;
            end
            used_q <= used_q + (PW+1)'(push_new) - (PW+1)'(retire);
        end
    end

    // Entry storage: open a new entry or extend the newest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                base_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
        end else if (push_new) begin
            base_q[tl_q] <= in_addr;
            cnt_q[tl_q]  <= CW'(1);
        end else if (push_merge) begin
            cnt_q[last_idx] <= cnt_q[last_idx] + 1'b1;
        end
    end
endmodule

// File: rtl/wbuf_data_q.sv
// Shared data slot pool. Words leave in arrival order, so the pool is a ring.
// A slot is freed when memory accepts its word.
// Assumes WORDS is a power of two and the caller never pushes when full.
module wbuf_data_q #(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data,
    output logic                     full,
    output logic [$clog2(WORDS):0]   used
);
    localparam int PW = $clog2(WORDS);

    logic [DW-1:0] slot_q [WORDS];
    logic [PW-1:0] rd_q, wr_q;
    logic [PW:0]   used_q;

    // Present the oldest word and the occupancy.
    always_comb begin
        rd_data = slot_q[rd_q];
        full    = (used_q == (PW+1)'(WORDS));
        used    = used_q;
    end

    // Ring pointers and slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            used_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            used_q <= used_q + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // Slot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[wr_q] <= wr_data;
        end
    end
endmodule

// File: rtl/wbuf_top.sv
// Posted write buffer top level.
// Decides whether each write is posted or direct, manages the address queue
// and the shared data pool, and steers the memory port.
// Assumes the processor holds a write stable until cpu_wr_ready is seen.
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_enable,
    input  logic          cpu_wr_valid,
    output logic          cpu_wr_ready,
    input  logic [AW-1:0] cpu_wr_addr,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          cpu_wr_cache,
    input  logic          cpu_wr_buf,
    input  logic          cpu_wr_locked,
    output logic          cpu_wr_abort,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    input  logic          mem_abort
);
    localparam int AUW = $clog2(ENTRIES) + 1;
    localparam int DUW = $clog2(WORDS) + 1;

    wb_route_e      route;
    logic           a_empty, a_full, d_full, merge_hit;
    logic           room, push, push_new, push_merge, drain;
    logic [AW-1:0]  head_addr;
    logic [DW-1:0]  head_data;
    logic [AUW-1:0] a_used;
    logic [DUW-1:0] d_used;

    // Classify the presented write as posted or direct.
    always_comb begin
        route = (wb_enable && (cpu_wr_cache || cpu_wr_buf) && !cpu_wr_locked)
                ? ROUTE_POSTED : ROUTE_DIRECT;
    end

    // Acceptance, queue control and memory port steering.
    always_comb begin
        room         = !d_full && (merge_hit || !a_full);
        push         = cpu_wr_valid && (route == ROUTE_POSTED) && room;
        push_new     = push && !merge_hit;
        push_merge   = push && merge_hit;
        drain        = !a_empty && mem_ready;
        cpu_wr_ready = cpu_wr_valid && ((route == ROUTE_POSTED) ? room
                                                                : (a_empty && mem_ready));
        cpu_wr_abort = cpu_wr_valid && (route == ROUTE_DIRECT) && a_empty
                       && mem_ready && mem_abort;
        mem_valid    = !a_empty || (cpu_wr_valid && (route == ROUTE_DIRECT));
        mem_addr     = a_empty ? cpu_wr_addr : head_addr;
        mem_data     = a_empty ? cpu_wr_data : head_data;
    end

    wbuf_addr_q #(.AW(AW), .ENTRIES(ENTRIES), .WORDS(WORDS)) u_addr_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_addr    (cpu_wr_addr),
        .push_new   (push_new),
        .push_merge (push_merge),
        .pop_word   (drain),
        .merge_hit  (merge_hit),
        .full       (a_full),
        .empty      (a_empty),
        .head_addr  (head_addr),
        .used       (a_used)
    );

    wbuf_data_q #(.DW(DW), .WORDS(WORDS)) u_data_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (drain),
        .wr_data (cpu_wr_data),
        .rd_data (head_data),
        .full    (d_full),
        .used    (d_used)
    );
endmodule

// File: rtl/wbuf_chk.sv
// Property checker for the posted write buffer, attached to wbuf_top by bind.
// Observes the ports and the two occupancy counts.
module wbuf_chk #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cpu_wr_valid,
    input logic                     cpu_wr_ready,
    input logic                     cpu_wr_abort,
    input logic                     mem_valid,
    input logic                     mem_ready,
    input logic [AW-1:0]            mem_addr,
    input logic [DW-1:0]            mem_data,
    input logic [$clog2(ENTRIES):0] a_used,
    input logic [$clog2(WORDS):0]   d_used
);
    // R3
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(a_used) <= ENTRIES) && (int'(d_used) <= WORDS));

    // R3
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_ready |-> cpu_wr_valid);

    // R4
    words_cover_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(d_used) >= int'(a_used)) && ((a_used == '0) == (d_used == '0)));

    // R2
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && (a_used != '0))
        |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6
    direct_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_abort |-> ((a_used == '0) && mem_valid && mem_ready && cpu_wr_ready));

    // R10
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_used == '0) && !cpu_wr_valid) |-> !mem_valid);
endmodule

bind wbuf_top wbuf_chk #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES), .WORDS(WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_valid (cpu_wr_valid),
    .cpu_wr_ready (cpu_wr_ready),
    .cpu_wr_abort (cpu_wr_abort),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .a_used       (a_used),
    .d_used       (d_used)
);

// File: tb/wbuf_top_tb_top.sv
// Bench for wbuf_top: a queue-based reference model compared on every cycle,
// plus scenario checks for stalls, merging, routing and aborts.
module wbuf_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        cv = 1'b0;
    logic [31:0] ca = '0;
    logic [31:0] cd = '0;
    logic        cc = 1'b0;
    logic        cb = 1'b0;
    logic        cl = 1'b0;
    logic        mr = 1'b0;
    logic        mab = 1'b0;
    logic        cpu_wr_ready, cpu_wr_abort, mem_valid;
    logic [31:0] mem_addr, mem_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int mr_mode = 0;  // 0 always ready, 1 never ready, 2 pseudo-random
    int txn = 0;

    logic [31:0] qa[$];
    int          qn[$];
    logic [31:0] qd[$];
    int          hoff = 0;
    bit          f_mem = 0, f_push = 0, f_merge = 0, f_direct = 0;

    wbuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .wb_enable(en),
        .cpu_wr_valid(cv), .cpu_wr_ready(cpu_wr_ready),
        .cpu_wr_addr(ca), .cpu_wr_data(cd),
        .cpu_wr_cache(cc), .cpu_wr_buf(cb), .cpu_wr_locked(cl),
        .cpu_wr_abort(cpu_wr_abort),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mr), .mem_abort(mab)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Memory ready pattern
    always @(posedge clk) begin
        #1;
        case (mr_mode)
            0:       mr = 1'b1;
            1:       mr = 1'b0;
            default: mr = ($urandom % 3) != 0;
        endcase
    end

    // Reference model prediction and comparison, away from the clock edge
    always @(negedge clk) begin : mon
        int n;
        bit empty, bufd, lastw, merge, room, er, emv, eab;
        logic [31:0] ea, ed;
        if (rst_n && !done) begin
            n     = qa.size();
            empty = (n == 0);
            bufd  = en && (cc || cb) && !cl;
            lastw = !empty && (hoff + 1 == qn[0]);
            merge = !empty && ((qa[n-1] + 32'(4*qn[n-1])) == ca)
                    && !(n == 1 && mr && lastw);
            room  = (qd.size() < 8) && (merge || n < 4);
            er    = cv && (bufd ? room : (empty && mr));
            emv   = !empty || (cv && !bufd);
            ea    = empty ? ca : qa[0] + 32'(4*hoff);
            ed    = empty ? cd : qd[0];
            eab   = cv && !bufd && empty && mr && mab;
            check(cpu_wr_ready == er, "R3 cpu_wr_ready", 32'(cpu_wr_ready), 32'(er));
            check(mem_valid == emv, "R10 mem_valid", 32'(mem_valid), 32'(emv));
            check(cpu_wr_abort == eab, "R9 cpu_wr_abort", 32'(cpu_wr_abort), 32'(eab));
            if (emv) begin
                check(mem_addr == ea, "R2 mem_addr", mem_addr, ea);
                check(mem_data == ed, "R2 mem_data", mem_data, ed);
            end
            f_mem    = !empty && mr;
            f_push   = cv && bufd && room;
            f_merge  = merge;
            f_direct = cv && !bufd && empty && mr;
        end
    end

    // Reference model state update at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            qa.delete(); qn.delete(); qd.delete(); hoff = 0;
        end else begin
            if (f_mem) begin
                txn++;
                void'(qd.pop_front());
                hoff++;
                if (hoff == qn[0]) begin
                    void'(qa.pop_front());
                    void'(qn.pop_front());
                    hoff = 0;
                end
            end
            if (f_direct) txn++;
            if (f_push) begin
                if (f_merge) qn[qn.size()-1] = qn[qn.size()-1] + 1;
                else begin qa.push_back(ca); qn.push_back(1); end
                qd.push_back(cd);
            end
        end
        f_mem = 0; f_push = 0; f_merge = 0; f_direct = 0;
    end

    // Present one write and hold it until accepted
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit c,
                      input bit b, input bit l, output int stalls, output bit ab);
        stalls = 0;
        cv = 1'b1; ca = a; cd = d; cc = c; cb = b; cl = l;
        @(negedge clk);
        while (!cpu_wr_ready) begin
            stalls++;
            @(negedge clk);
        end
        ab = cpu_wr_abort;
        @(posedge clk); #1;
        cv = 1'b0;
    endtask

    task automatic drain_all;
        mr_mode = 0;
        while (qa.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic release_after(input int cyc);
        repeat (cyc) @(posedge clk);
        mr_mode = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        int st, st2, t0;
        bit ab;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(mem_valid == 1'b0, "R1 idle after reset", 32'(mem_valid), 0);
        @(posedge clk); #1;

        // Scattered posted writes, random memory readiness
        mr_mode = 2;
        for (int i = 0; i < 12; i++)
            wr(32'h100 + 32'(i*24), 32'hA000 + 32'(i), 1'b0, 1'b1, 1'b0, st, ab);
        // Consecutive runs to hit the join/open boundary (R4)
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < 5; i++)
                wr(32'h4000 + 32'(k*256) + 32'(i*4), 32'hB000 + 32'(k*16+i),
                   1'b1, 1'b0, 1'b0, st, ab);
        drain_all();

        // R4: eight consecutive words fit in one entry with memory stalled
        mr_mode = 1;
        @(posedge clk); #1;
        st2 = 0;
        for (int i = 0; i < 8; i++) begin
            wr(32'h1000 + 32'(i*4), 32'hC000 + 32'(i), 1'b0, 1'b1, 1'b0, st, ab);
            st2 += st;
        end
        check(st2 == 0, "R4 run of 8 joins one entry", 32'(st2), 0);
        // R3: ninth word finds the pool full
        fork
            wr(32'h1020, 32'hC008, 1'b0, 1'b1, 1'b0, st, ab);
            release_after(6);
        join
        check(st >= 4, "R3 data pool full stalls", 32'(st), 4);
        drain_all();

        // R3: fifth scattered write finds no free entry
        mr_mode = 1;
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++)
            wr(32'h2000 + 32'(i*256), 32'hD000 + 32'(i), 1'b0, 1'b1, 1'b0, st, ab);
        fork
            wr(32'h2800, 32'hD004, 1'b0, 1'b1, 1'b0, st, ab);
            release_after(6);
        join
        check(st >= 4, "R3 entries full stalls", 32'(st), 4);
        drain_all();

        // R5 and R6: unregulated region waits for the buffer to empty
        mr_mode = 1;
        @(posedge clk); #1;
        wr(32'h3000, 32'hE000, 1'b1, 1'b1, 1'b0, st, ab);
        wr(32'h3100, 32'hE001, 1'b0, 1'b1, 1'b0, st, ab);
        fork
            wr(32'h3200, 32'hE002, 1'b0, 1'b0, 1'b0, st, ab);
            release_after(4);
        join
        check(st >= 4, "R5 R6 direct write waits for empty", 32'(st), 4);
        drain_all();

        // R7: locked write with both attributes set is still direct
        mr_mode = 1;
        @(posedge clk); #1;
        wr(32'h3300, 32'hE010, 1'b0, 1'b1, 1'b0, st, ab);
        fork
            wr(32'h3304, 32'hE011, 1'b1, 1'b1, 1'b1, st, ab);
            release_after(4);
        join
        check(st >= 4, "R7 locked write waits for empty", 32'(st), 4);
        drain_all();

        // R8: clearing enable lets queued writes drain; new writes go direct
        mr_mode = 1;
        @(posedge clk); #1;
        t0 = txn;
        for (int i = 0; i < 3; i++)
            wr(32'h5000 + 32'(i*64), 32'hF000 + 32'(i), 1'b0, 1'b1, 1'b0, st, ab);
        en = 1'b0;
        fork
            wr(32'h5400, 32'hF003, 1'b1, 1'b1, 1'b0, st, ab);
            release_after(3);
        join
        check(st >= 3, "R8 disabled write waits", 32'(st), 3);
        drain_all();
        check(txn - t0 == 4, "R8 queued writes all drained", 32'(txn - t0), 4);
        en = 1'b1;

        // R9: abort ignored on posted writes, reported on direct writes
        mr_mode = 0;
        mab = 1'b1;
        wr(32'h6000, 32'h1111, 1'b0, 1'b1, 1'b0, st, ab);
        check(ab == 1'b0, "R9 posted write no abort", 32'(ab), 0);
        repeat (3) @(posedge clk); #1;
        wr(32'h6004, 32'h2222, 1'b0, 1'b0, 1'b0, st, ab);
        check(ab == 1'b1, "R9 direct write abort returned", 32'(ab), 1);
        mab = 1'b0;
        drain_all();

        // R1: reset empties a partly filled buffer
        mr_mode = 1;
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++)
            wr(32'h7000 + 32'(i*4), 32'h3000 + 32'(i), 1'b0, 1'b1, 1'b0, st, ab);
        t0 = txn;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1; mr_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_valid == 1'b0, "R1 reset discards queue", 32'(mem_valid), 0);
        check(txn == t0, "R1 nothing drained after reset", 32'(txn), 32'(t0));
        @(posedge clk); #1;

        finish_up();
    end
endmodule